// File: doc/BRIEF.md
# Programmable Reversible Gate Cascade

This block evaluates a reversible Boolean function on a small vector of data lines. The vector passes through an ordered chain of gate slots. Each slot is loaded at run time through a write-only configuration port. A slot holds one of three things: a multiple-controlled NOT (which covers plain NOT, the two-line controlled NOT and the three-line form), a multiple-controlled swap, or nothing, in which case the slot passes the vector through unchanged. Every line goes into exactly one gate input and comes out of exactly one gate output. There is no fan-out and no feedback.

Each input vector comes with a valid strobe and a direction bit. In the forward direction the slots are applied from slot 0 upward. In the reverse direction they are applied from the last slot down to slot 0. Every gate is its own inverse, so the reverse direction computes the inverse function. A parameter chooses whether each stage is registered, which gives one vector per cycle and a latency of one cycle per slot, or whether the whole chain is combinational with zero latency.

The configuration port checks each write. A write that cannot form a legal gate is dropped. A two-state checker FSM then moves from state CFG_CLEAN to state CFG_FAULT, through the transition "bad write", and raises the error output. It returns to CFG_CLEAN, through the transition "good write", on the next accepted write. Any other cycle keeps the current state.

Top module: `rgc_cascade`

## Requirements
- R1: After reset every slot is empty (kind code 0), and an empty slot leaves the vector unchanged. Line i is bit i of the data vector.
- R2: A slot of kind code 1 inverts the line selected by its first target index exactly when every line set in its control mask is 1. An all-zero mask therefore makes it an unconditional NOT. All other lines pass unchanged.
- R3: A slot of kind code 2 exchanges the lines selected by its two target indices exactly when every line set in its control mask is 1. Otherwise it leaves them unchanged.
- R4: With the direction input at 0, slots are applied in ascending order, so slot 0 acts first.
- R5: With the direction input at 1, slots are applied in descending order, so the result is the inverse of the forward mapping.
- R6: A configuration write is dropped, and the slot keeps its previous contents, when any of these holds: the kind is code 3; the slot index is not below the slot count; for a non-empty kind, the first target index is not below the line count or is set in the mask; for kind 2, the second target index is out of range, equals the first target, or is set in the mask. A write of kind 0 is always accepted.
- R7: The error output is 0 after reset. It becomes 1 in the cycle after a dropped write, becomes 0 in the cycle after an accepted write, and otherwise holds its value.
- R8: When registered, out_valid rises exactly N_SLOTS clock cycles after the matching in_valid, and it is 0 after reset.
- R9: When registered, vectors may be presented on consecutive cycles. Each vector leaves with its own direction applied, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | SLOT_W | Slot index to write |
| cfg_kind | input | 2 | Gate kind: 0 empty, 1 controlled NOT, 2 controlled swap, 3 reserved |
| cfg_mask | input | N_LINES | Control-line mask |
| cfg_ta | input | IDX_W | First target line index |
| cfg_tb | input | IDX_W | Second target line index (swap only) |
| cfg_err | output | 1 | High while the last write was dropped |
| in_valid | input | 1 | Input vector strobe |
| in_rev | input | 1 | 1 = apply slots in reverse order |
| in_data | input | N_LINES | Input vector |
| out_valid | output | 1 | Output vector strobe |
| out_data | output | N_LINES | Output vector |

## Verification
The bench goes after the slot order first. A chain that applied the slots in a fixed order whatever the direction bit would still pass single-gate tests, but it fails when a NOT feeding a controlled NOT is run in both directions and when a forward result is fed back through the reverse direction. Controls on lines that are 0, empty masks and swaps with the control held low are all exercised. A gate that ignored its mask or swapped without a condition would therefore change vectors that must come out unchanged. Each illegal write form is followed by traffic that shows the slot was kept. A checker that missed a case, or that let a bad write through, shows up both as a wrong error flag and as changed outputs. Back-to-back vectors of mixed direction expose a stage that takes its direction from the wrong place or drops a cycle.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
    typedef enum logic [1:0] {
        KIND_EMPTY = 2'd0,
        KIND_CNOT  = 2'd1,
        KIND_SWAP  = 2'd2,
        KIND_RSVD  = 2'd3
    } gate_kind_e;

    typedef enum logic {
        CFG_CLEAN = 1'b0,
        CFG_FAULT = 1'b1
    } cfg_state_e;
endpackage

// File: rtl/rgc_gate.sv
module rgc_gate
    import rgc_pkg::*;
#(
    parameter int N_LINES = 3,
    parameter int IDX_W   = 2
) (
    input  gate_kind_e           kind,
    input  logic [N_LINES-1:0]   mask,
    input  logic [IDX_W-1:0]     ta,
    input  logic [IDX_W-1:0]     tb,
    input  logic [N_LINES-1:0]   v_in,
    output logic [N_LINES-1:0]   v_out
);
    logic all_on;
    logic line_a;
    logic line_b;

    always_comb begin
        all_on = &(v_in | ~mask);
        line_a = 1'b0;
        line_b = 1'b0;
        for (int i = 0; i < N_LINES; i++) begin
            if (ta == IDX_W'(i)) line_a = v_in[i];
            if (tb == IDX_W'(i)) line_b = v_in[i];
        end
        v_out = v_in;
        for (int i = 0; i < N_LINES; i++) begin
            unique case (kind)
                KIND_CNOT: begin
                    if (ta == IDX_W'(i)) v_out[i] = v_in[i] ^ all_on;
                end
                KIND_SWAP: begin
                    if (all_on && ta == IDX_W'(i)) v_out[i] = line_b;
                    if (all_on && tb == IDX_W'(i)) v_out[i] = line_a;
                end
                default: v_out[i] = v_in[i];
            endcase
        end
    end
endmodule

// File: rtl/rgc_slot_bank.sv
module rgc_slot_bank
    import rgc_pkg::*;
#(
    parameter int N_LINES = 3,
    parameter int N_SLOTS = 8,
    parameter int IDX_W   = 2,
    parameter int SLOT_W  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cfg_we,
    input  logic [SLOT_W-1:0]               cfg_slot,
    input  logic [1:0]                      cfg_kind,
    input  logic [N_LINES-1:0]              cfg_mask,
    input  logic [IDX_W-1:0]                cfg_ta,
    input  logic [IDX_W-1:0]                cfg_tb,
    output logic                            cfg_err,
    output logic [N_SLOTS-1:0][1:0]         s_kind,
    output logic [N_SLOTS-1:0][N_LINES-1:0] s_mask,
    output logic [N_SLOTS-1:0][IDX_W-1:0]   s_ta,
    output logic [N_SLOTS-1:0][IDX_W-1:0]   s_tb
);
    cfg_state_e st_q;
    cfg_state_e st_nx;
    logic       bad;
    logic       slot_oob;
    logic       ta_oob;
    logic       tb_oob;
    logic       ta_in_mask;
    logic       tb_in_mask;
    gate_kind_e kind_w;

    always_comb begin
        kind_w     = gate_kind_e'(cfg_kind);
        slot_oob   = {1'b0, cfg_slot} >= (SLOT_W+1)'(N_SLOTS);
        ta_oob     = {1'b0, cfg_ta}   >= (IDX_W+1)'(N_LINES);
        tb_oob     = {1'b0, cfg_tb}   >= (IDX_W+1)'(N_LINES);
        ta_in_mask = 1'b0;
        tb_in_mask = 1'b0;
        for (int j = 0; j < N_LINES; j++) begin
            if (cfg_ta == IDX_W'(j)) ta_in_mask = cfg_mask[j];
            if (cfg_tb == IDX_W'(j)) tb_in_mask = cfg_mask[j];
        end
        unique case (kind_w)
            KIND_EMPTY: bad = slot_oob;
            KIND_CNOT:  bad = slot_oob | ta_oob | ta_in_mask;
            KIND_SWAP:  bad = slot_oob | ta_oob | ta_in_mask | tb_oob
                              | tb_in_mask | (cfg_ta == cfg_tb);
            default:    bad = 1'b1;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CFG_CLEAN;
        else        st_q <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            CFG_CLEAN: if (cfg_we && bad)  st_nx = CFG_FAULT;
            CFG_FAULT: if (cfg_we && !bad) st_nx = CFG_CLEAN;
            default:   st_nx = CFG_CLEAN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (st_q)
            CFG_FAULT: cfg_err = 1'b1;
            default:   cfg_err = 1'b0;
        endcase
    end

    // slot storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_kind <= '0;
            s_mask <= '0;
            s_ta   <= '0;
            s_tb   <= '0;
        end else if (cfg_we && !bad) begin
            s_kind[cfg_slot] <= cfg_kind;
            s_mask[cfg_slot] <= cfg_mask;
            s_ta[cfg_slot]   <= cfg_ta;
            s_tb[cfg_slot]   <= cfg_tb;
        end
    end
endmodule

// File: rtl/rgc_stage.sv
module rgc_stage
    import rgc_pkg::*;
#(
    parameter int N_LINES    = 3,
    parameter int IDX_W      = 2,
    parameter bit REGISTERED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               v_i,
    input  logic               r_i,
    input  logic [N_LINES-1:0] d_i,
    input  gate_kind_e         kind,
    input  logic [N_LINES-1:0] mask,
    input  logic [IDX_W-1:0]   ta,
    input  logic [IDX_W-1:0]   tb,
    output logic               v_o,
    output logic               r_o,
    output logic [N_LINES-1:0] d_o
);
    logic [N_LINES-1:0] g_out;

    rgc_gate #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_gate (
        .kind (kind),
        .mask (mask),
        .ta   (ta),
        .tb   (tb),
        .v_in (d_i),
        .v_out(g_out)
    );

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v_o <= 1'b0;
                    r_o <= 1'b0;
                    d_o <= '0;
                end else begin
                    v_o <= v_i;
                    r_o <= r_i;
                    d_o <= g_out;
                end
            end
        end else begin : g_comb
            assign v_o = v_i;
            assign r_o = r_i;
            assign d_o = g_out;
        end
    endgenerate
endmodule

// File: rtl/rgc_cascade.sv
module rgc_cascade
    import rgc_pkg::*;
#(
    parameter int N_LINES    = 3,
    parameter int N_SLOTS    = 8,
    parameter bit REGISTERED = 1'b1,
    localparam int IDX_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [SLOT_W-1:0]  cfg_slot,
    input  logic [1:0]         cfg_kind,
    input  logic [N_LINES-1:0] cfg_mask,
    input  logic [IDX_W-1:0]   cfg_ta,
    input  logic [IDX_W-1:0]   cfg_tb,
    output logic               cfg_err,
    input  logic               in_valid,
    input  logic               in_rev,
    input  logic [N_LINES-1:0] in_data,
    output logic               out_valid,
    output logic [N_LINES-1:0] out_data
);
    logic [N_SLOTS-1:0][1:0]         s_kind;
    logic [N_SLOTS-1:0][N_LINES-1:0] s_mask;
    logic [N_SLOTS-1:0][IDX_W-1:0]   s_ta;
    logic [N_SLOTS-1:0][IDX_W-1:0]   s_tb;

    logic [N_SLOTS:0]              vld;
    logic [N_SLOTS:0]              rev;
    logic [N_SLOTS:0][N_LINES-1:0] dat;

    rgc_slot_bank #(
        .N_LINES(N_LINES), .N_SLOTS(N_SLOTS), .IDX_W(IDX_W), .SLOT_W(SLOT_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_we  (cfg_we),
        .cfg_slot(cfg_slot),
        .cfg_kind(cfg_kind),
        .cfg_mask(cfg_mask),
        .cfg_ta  (cfg_ta),
        .cfg_tb  (cfg_tb),
        .cfg_err (cfg_err),
        .s_kind  (s_kind),
        .s_mask  (s_mask),
        .s_ta    (s_ta),
        .s_tb    (s_tb)
    );

    assign vld[0] = in_valid;
    assign rev[0] = in_rev;
    assign dat[0] = in_data;

    generate
        for (genvar k = 0; k < N_SLOTS; k++) begin : g_stage
            logic [SLOT_W-1:0] sel;
            assign sel = rev[k] ? SLOT_W'(N_SLOTS - 1 - k) : SLOT_W'(k);

            rgc_stage #(
                .N_LINES(N_LINES), .IDX_W(IDX_W), .REGISTERED(REGISTERED)
            ) u_stage (
                .clk  (clk),
                .rst_n(rst_n),
                .v_i  (vld[k]),
                .r_i  (rev[k]),
                .d_i  (dat[k]),
                .kind (gate_kind_e'(s_kind[sel])),
                .mask (s_mask[sel]),
                .ta   (s_ta[sel]),
                .tb   (s_tb[sel]),
                .v_o  (vld[k+1]),
                .r_o  (rev[k+1]),
                .d_o  (dat[k+1])
            );
        end
    endgenerate

    assign out_valid = vld[N_SLOTS];
    assign out_data  = dat[N_SLOTS];
endmodule

// File: rtl/rgc_checker.sv
module rgc_checker #(
    parameter int N_LINES    = 3,
    parameter int N_SLOTS    = 8,
    parameter bit REGISTERED = 1'b1,
    parameter int IDX_W      = 2,
    parameter int SLOT_W     = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            cfg_we,
    input logic [SLOT_W-1:0]               cfg_slot,
    input logic [1:0]                      cfg_kind,
    input logic [N_LINES-1:0]              cfg_mask,
    input logic [IDX_W-1:0]                cfg_ta,
    input logic [IDX_W-1:0]                cfg_tb,
    input logic                            cfg_err,
    input logic [N_SLOTS:0]                vld,
    input logic [N_SLOTS-1:0][1:0]         s_kind,
    input logic [N_SLOTS-1:0][N_LINES-1:0] s_mask,
    input logic [N_SLOTS-1:0][IDX_W-1:0]   s_ta,
    input logic [N_SLOTS-1:0][IDX_W-1:0]   s_tb
);
    logic ill;
    always_comb begin
        ill = 1'b0;
        if (int'(cfg_slot) >= N_SLOTS) ill = 1'b1;
        if (cfg_kind == 2'd3) ill = 1'b1;
        if (cfg_kind != 2'd0) begin
            if (int'(cfg_ta) >= N_LINES) ill = 1'b1;
            else if (((cfg_mask >> cfg_ta) & N_LINES'(1)) != '0) ill = 1'b1;
        end
        if (cfg_kind == 2'd2) begin
            if (int'(cfg_tb) >= N_LINES || cfg_tb == cfg_ta) ill = 1'b1;
            else if (((cfg_mask >> cfg_tb) & N_LINES'(1)) != '0) ill = 1'b1;
        end
    end

    // R6: a dropped write leaves every slot untouched
    a_r6_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ill) |=> ($stable(s_kind) && $stable(s_mask)
                             && $stable(s_ta) && $stable(s_tb)));

    // R7: flag raised after a dropped write
    a_r7_err_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ill) |=> cfg_err);

    // R7: flag cleared after an accepted write
    a_r7_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !ill) |=> !cfg_err);

    // R7: flag holds without writes
    a_r7_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(cfg_err));

    generate
        if (REGISTERED) begin : g_step
            for (genvar k = 0; k < N_SLOTS; k++) begin : g_k
                // R8: each stage delays the strobe by exactly one cycle
                a_r8_stage_step: assert property (@(posedge clk) disable iff (!rst_n)
                    vld[k+1] == $past(vld[k]));
            end
        end
    endgenerate
endmodule

bind rgc_cascade rgc_checker #(
    .N_LINES(N_LINES), .N_SLOTS(N_SLOTS), .REGISTERED(REGISTERED),
    .IDX_W(IDX_W), .SLOT_W(SLOT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_slot(cfg_slot),
    .cfg_kind(cfg_kind),
    .cfg_mask(cfg_mask),
    .cfg_ta  (cfg_ta),
    .cfg_tb  (cfg_tb),
    .cfg_err (cfg_err),
    .vld     (vld),
    .s_kind  (s_kind),
    .s_mask  (s_mask),
    .s_ta    (s_ta),
    .s_tb    (s_tb)
);

// File: tb/sim_rgc_cascade.sv
`timescale 1ns/1ps
module sim_rgc_cascade;
    localparam int NL = 3;
    localparam int NS = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_slot = '0;
    logic [1:0] cfg_kind = '0;
    logic [2:0] cfg_mask = '0;
    logic [1:0] cfg_ta = '0;
    logic [1:0] cfg_tb = '0;
    logic       cfg_err;
    logic       in_valid = 1'b0;
    logic       in_rev = 1'b0;
    logic [2:0] in_data = '0;
    logic       out_valid;
    logic [2:0] out_data;

    always #2 clk = ~clk;

    rgc_cascade #(.N_LINES(NL), .N_SLOTS(NS), .REGISTERED(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_kind(cfg_kind), .cfg_mask(cfg_mask), .cfg_ta(cfg_ta),
        .cfg_tb(cfg_tb), .cfg_err(cfg_err), .in_valid(in_valid),
        .in_rev(in_rev), .in_data(in_data), .out_valid(out_valid),
        .out_data(out_data)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [1:0] m_kind[NS];
    logic [2:0] m_mask[NS];
    int         m_ta[NS];
    int         m_tb[NS];

    logic [2:0] exp_q[$];
    string      tag_q[$];

    task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] model(logic [2:0] x, bit rv);
        logic [2:0] v;
        v = x;
        for (int k = 0; k < NS; k++) begin
            int   s;
            logic on;
            logic t;
            s  = rv ? NS - 1 - k : k;
            on = &(v | ~m_mask[s]);
            if (m_kind[s] == 2'd1 && on) v[m_ta[s]] = ~v[m_ta[s]];
            if (m_kind[s] == 2'd2 && on) begin
                t = v[m_ta[s]];
                v[m_ta[s]] = v[m_tb[s]];
                v[m_tb[s]] = t;
            end
        end
        return v;
    endfunction

    function automatic bit is_bad(int kind, logic [2:0] mask, int ta, int tb);
        if (kind == 3) return 1'b1;
        if (kind == 0) return 1'b0;
        if (ta >= NL || mask[ta]) return 1'b1;
        if (kind == 2 && (tb >= NL || tb == ta || mask[tb])) return 1'b1;
        return 1'b0;
    endfunction

    // output monitor
    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R8 unexpected out_valid actual=1 expected=0");
            end else begin
                logic [2:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, out_data, e);
            end
        end
    end

    task automatic send(logic [2:0] d, bit rv, string tag, bit use_lit, logic [2:0] lit);
        in_valid = 1'b1;
        in_rev   = rv;
        in_data  = d;
        exp_q.push_back(use_lit ? lit : model(d, rv));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        int guard;
        guard = 0;
        while (exp_q.size() != 0 && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic cfg_write(int slot, int kind, logic [2:0] mask, int ta, int tb);
        bit bad;
        bad = is_bad(kind, mask, ta, tb);
        cfg_we   = 1'b1;
        cfg_slot = 3'(slot);
        cfg_kind = 2'(kind);
        cfg_mask = mask;
        cfg_ta   = 2'(ta);
        cfg_tb   = 2'(tb);
        @(negedge clk);
        cfg_we = 1'b0;
        check("R7 error flag after write", {2'b0, cfg_err}, {2'b0, bad});
        if (!bad) begin
            m_kind[slot] = 2'(kind);
            m_mask[slot] = mask;
            m_ta[slot]   = ta;
            m_tb[slot]   = tb;
        end
    endtask

    task automatic clear_all();
        for (int s = 0; s < NS; s++) cfg_write(s, 0, 3'b000, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_v;
        int          cnt;
        seed_v = $urandom(32'd4711);
        for (int s = 0; s < NS; s++) begin
            m_kind[s] = '0; m_mask[s] = '0; m_ta[s] = 0; m_tb[s] = 0;
        end
        repeat (3) @(negedge clk);
        check("R8 out_valid in reset", {2'b0, out_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 out_valid after reset", {2'b0, out_valid}, 3'b000);
        check("R7 error flag after reset", {2'b0, cfg_err}, 3'b000);

        // R1: empty cascade is identity
        send(3'b101, 1'b0, "R1 empty identity", 1'b1, 3'b101);
        send(3'b010, 1'b1, "R1 empty identity reverse", 1'b1, 3'b010);
        drain();

        // R8: latency
        in_valid = 1'b1; in_data = 3'b110; in_rev = 1'b0;
        exp_q.push_back(3'b110); tag_q.push_back("R8 latency data");
        @(negedge clk);
        in_valid = 1'b0;
        cnt = 1;
        while (!out_valid && cnt < 50) begin
            @(negedge clk);
            cnt++;
        end
        check("R8 latency cycles", 3'(cnt), 3'(NS));
        drain();

        // R2: unconditional NOT
        cfg_write(0, 1, 3'b000, 1, 0);
        send(3'b101, 1'b0, "R2 NOT line1", 1'b1, 3'b111);
        send(3'b111, 1'b0, "R2 NOT line1", 1'b1, 3'b101);
        drain();
        // R2: controlled NOT with one control
        cfg_write(0, 1, 3'b001, 2, 0);
        send(3'b001, 1'b0, "R2 one control on", 1'b1, 3'b101);
        send(3'b100, 1'b0, "R2 one control off", 1'b1, 3'b100);
        drain();
        // R2: two controls
        cfg_write(0, 1, 3'b011, 2, 0);
        send(3'b011, 1'b0, "R2 two controls on", 1'b1, 3'b111);
        send(3'b001, 1'b0, "R2 two controls partial", 1'b1, 3'b001);
        drain();

        // R3: controlled swap
        cfg_write(0, 0, 3'b000, 0, 0);
        cfg_write(1, 2, 3'b001, 1, 2);
        send(3'b011, 1'b0, "R3 swap ctrl on", 1'b1, 3'b101);
        send(3'b010, 1'b0, "R3 swap ctrl off", 1'b1, 3'b010);
        drain();
        cfg_write(1, 2, 3'b100, 0, 1);
        send(3'b110, 1'b0, "R3 swap lines 0 1", 1'b1, 3'b101);
        send(3'b000, 1'b0, "R3 swap equal lines", 1'b1, 3'b000);
        drain();

        // R4 and R5: order
        cfg_write(0, 1, 3'b000, 0, 0);
        cfg_write(1, 1, 3'b001, 1, 0);
        send(3'b000, 1'b0, "R4 forward order", 1'b1, 3'b011);
        send(3'b000, 1'b1, "R5 reverse order", 1'b1, 3'b001);
        send(3'b011, 1'b1, "R5 inverse of forward", 1'b1, 3'b000);
        drain();

        // R6: dropped writes keep slot 1
        cfg_write(1, 1, 3'b010, 1, 0);
        cfg_write(1, 3, 3'b000, 0, 0);
        check("R7 flag held while idle", {2'b0, cfg_err}, 3'b001);
        cfg_write(1, 2, 3'b000, 2, 2);
        cfg_write(1, 1, 3'b000, 3, 0);
        cfg_write(1, 2, 3'b100, 0, 2);
        send(3'b000, 1'b0, "R6 slot kept after dropped writes", 1'b1, 3'b011);
        drain();
        cfg_write(1, 0, 3'b111, 1, 1);
        check("R7 flag cleared", {2'b0, cfg_err}, 3'b000);
        send(3'b000, 1'b0, "R6 empty write accepted", 1'b1, 3'b001);
        drain();

        // R9: random back-to-back traffic, then random configurations
        for (int i = 0; i < 24; i++)
            send(3'($urandom), 1'($urandom), "R9 back-to-back", 1'b0, 3'b000);
        drain();
        for (int r = 0; r < 30; r++) begin
            logic [2:0] x;
            logic [2:0] y;
            cfg_write(int'($urandom_range(0, NS - 1)), int'($urandom_range(0, 3)),
                      3'($urandom), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
            for (int i = 0; i < 6; i++)
                send(3'($urandom), 1'($urandom), "R9 random mixed direction", 1'b0, 3'b000);
            x = 3'($urandom);
            y = model(x, 1'b0);
            send(x, 1'b0, "R4 random forward", 1'b0, 3'b000);
            send(y, 1'b1, "R5 random inverse", 1'b1, x);
            drain();
        end

        check("R8 no outstanding vectors", 3'(exp_q.size()), 3'b000);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule